// File: doc/BRIEF.md
# Sequencer Program Store Loader

This block holds the instruction store of an embedded sequencer and lets a host fill and inspect it through a narrow register port. The store is 512 words of 32 bits. The host reaches it through four byte-wide registers: a control register, a data window, and a word pointer split into a low byte and a one-bit high register. Loading a word takes four consecutive writes to the data window. Each byte goes into a holding register, and the complete word is written into the array when the final, most significant byte arrives.

The pointer steps to the next word after the fourth byte of a word has been moved, whether that byte was written or read. The host can therefore stream a whole program, or read it back, without rewriting the pointer between words. A two-bit lane counter tracks which byte of the current word comes next. The control register holds a load enable and a sequencer reset. While the load enable is clear, writes to the window are discarded. While the sequencer reset is set, the pointer is held at word 0. A separate registered fetch port lets the sequencer read whole words.

Top module: `seq_pram_loader`

## Requirements
- R1: Four writes to the data window (select code 1) while the load enable is set, taken least significant byte first, store the word {b3,b2,b1,b0} at the pointed word. The array changes only on the fourth write.
- R2: The word pointer increments by one after the fourth window byte (lane 3) and stays put after lanes 0 to 2. It wraps from 511 to 0.
- R3: Select code 2 reads and writes pointer bits 7:0. Select code 3 reads and writes pointer bit 8 in data bit 0, and its bits 7:1 read as 0.
- R4: The control register (select code 0) keeps data bit 0 as the load enable and bit 1 as the sequencer reset. Both appear on the load_en and seq_rst outputs, and the other read bits are 0.
- R5: A window write while the load enable is clear leaves the array, the lane counter and the pointer unchanged.
- R6: A window read returns byte `lane` of the pointed word, with lane 0 being bits 7:0, and advances the lane. After the fourth read the pointer increments.
- R7: A write to either pointer register returns the lane counter to 0, so the next window access is byte 0.
- R8: While the sequencer reset is set, the pointer and the lane are held at 0. Pointer writes and window accesses then do not move them.
- R9: fetch_data shows the word at fetch_addr one clock after fetch_addr is presented.
- R10: After reset, the control register, the pointer and the lane are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Register select: 0 control, 1 data window, 2 pointer low, 3 pointer high |
| host_wr | input | 1 | Write strobe for the selected register |
| host_rd | input | 1 | Read strobe; it only has an effect on the data window |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Value of the selected register (combinational) |
| load_en | output | 1 | Load enable bit of the control register |
| seq_rst | output | 1 | Sequencer reset bit of the control register |
| fetch_addr | input | 9 | Sequencer fetch word address |
| fetch_data | output | 32 | Registered fetch word |

## Verification
The assertions assume that the host never raises host_wr and host_rd in the same cycle, and they check that assumption as well. They also assume that host_rdata is meaningful only for the register currently selected. The stimulus performs exactly one operation per cycle and holds host_sel stable for that cycle. Window reads are compared only for words the bench has already written, because the array itself is not reset.

// File: rtl/seq_pram_pkg.sv
package seq_pram_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_DATA    = 2'd1,
    SEL_ADDR_LO = 2'd2,
    SEL_ADDR_HI = 2'd3
  } host_sel_e;

  localparam int CTRL_LOAD_BIT = 0;
  localparam int CTRL_RST_BIT  = 1;
  localparam int CTRL_W        = 2;
endpackage

// File: rtl/seq_pram_regs.sv
module seq_pram_regs
  import seq_pram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BYTE_W = 8,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [CTRL_W-1:0] ctrl,
  output logic [ADDR_W-1:0] word_addr,
  output logic [LANE_W-1:0] lane,
  output logic              data_wr_stb
);
  localparam int HI_W = ADDR_W - BYTE_W;
  localparam logic [LANE_W-1:0] LANE_LAST = {LANE_W{1'b1}};

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              in_reset, loading, data_rd_stb, step;

  assign in_reset    = ctrl_q[CTRL_RST_BIT];
  assign loading     = ctrl_q[CTRL_LOAD_BIT];
  assign data_wr_stb = host_wr && (host_sel == SEL_DATA) && loading && !in_reset;
  assign data_rd_stb = host_rd && !host_wr && (host_sel == SEL_DATA) && !in_reset;
  assign step        = data_wr_stb || data_rd_stb;

  always_comb begin
    ctrl_d = ctrl_q;
    addr_d = addr_q;
    lane_d = lane_q;
    if (host_wr && host_sel == SEL_CTRL)
      ctrl_d = host_wdata[CTRL_W-1:0];
    if (in_reset) begin
      addr_d = '0;
      lane_d = '0;
    end else if (host_wr && host_sel == SEL_ADDR_LO) begin
      addr_d[BYTE_W-1:0] = host_wdata;
      lane_d = '0;
    end else if (host_wr && host_sel == SEL_ADDR_HI) begin
      addr_d[ADDR_W-1:BYTE_W] = host_wdata[HI_W-1:0];
      lane_d = '0;
    end else if (step) begin
      if (lane_q == LANE_LAST) begin
        lane_d = '0;
        addr_d = addr_q + 1'b1;
      end else begin
        lane_d = lane_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
      lane_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      addr_q <= addr_d;
      lane_q <= lane_d;
    end
  end

  assign ctrl      = ctrl_q;
  assign word_addr = addr_q;
  assign lane      = lane_q;
endmodule

// File: rtl/seq_pram_assemble.sv
module seq_pram_assemble #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_stb,
  input  logic [LANE_W-1:0]       lane,
  input  logic [BYTE_W-1:0]       wdata,
  output logic                    commit,
  output logic [BYTE_W*LANES-1:0] commit_word
);
  localparam int HOLD_W = BYTE_W * (LANES - 1);
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);

  logic [HOLD_W-1:0] hold;

  for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
    logic              en;
    logic [BYTE_W-1:0] byte_q;
    assign en = wr_stb && (lane == LANE_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  byte_q <= '0;
      else if (en) byte_q <= wdata;
    end
    assign hold[g*BYTE_W +: BYTE_W] = byte_q;
  end

  assign commit      = wr_stb && (lane == LANE_LAST);
  assign commit_word = {wdata, hold};
endmodule

// File: rtl/seq_pram_array.sv
module seq_pram_array #(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [WORD_W-1:0] host_word,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [WORD_W-1:0] fetch_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] fetch_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fetch_q <= '0;
    else        fetch_q <= mem[fetch_addr];
  end

  assign host_word  = mem[host_addr];
  assign fetch_word = fetch_q;
endmodule

// File: rtl/seq_pram_loader.sv
module seq_pram_loader
  import seq_pram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              load_en,
  output logic              seq_rst,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [WORD_W-1:0] fetch_data
);
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);
  localparam int HI_W   = ADDR_W - BYTE_W;

  logic [CTRL_W-1:0] ctrl;
  logic [ADDR_W-1:0] word_addr;
  logic [LANE_W-1:0] lane;
  logic              data_wr_stb, commit;
  logic [WORD_W-1:0] commit_word, host_word;

  seq_pram_regs #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANE_W(LANE_W)) u_regs (
    .clk, .rst_n, .host_sel, .host_wr, .host_rd, .host_wdata,
    .ctrl, .word_addr, .lane, .data_wr_stb
  );

  seq_pram_assemble #(.BYTE_W(BYTE_W), .LANES(LANES), .LANE_W(LANE_W)) u_asm (
    .clk, .rst_n, .wr_stb(data_wr_stb), .lane, .wdata(host_wdata),
    .commit, .commit_word
  );

  seq_pram_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk, .rst_n, .we(commit), .waddr(word_addr), .wdata(commit_word),
    .host_addr(word_addr), .host_word,
    .fetch_addr, .fetch_word(fetch_data)
  );

  always_comb begin
    host_rdata = '0;
    case (host_sel)
      SEL_CTRL:    host_rdata[CTRL_W-1:0] = ctrl;
      SEL_DATA:    host_rdata = host_word[lane*BYTE_W +: BYTE_W];
      SEL_ADDR_LO: host_rdata = word_addr[BYTE_W-1:0];
      default:     host_rdata[HI_W-1:0] = word_addr[ADDR_W-1:BYTE_W];
    endcase
  end

  assign load_en = ctrl[CTRL_LOAD_BIT];
  assign seq_rst = ctrl[CTRL_RST_BIT];
endmodule

// File: rtl/seq_pram_loader_sva.sv
module seq_pram_loader_sva #(
  parameter int ADDR_W = 9,
  parameter int LANE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        host_sel,
  input logic              host_wr,
  input logic              host_rd,
  input logic [7:0]        host_rdata,
  input logic              load_en,
  input logic              seq_rst,
  input logic [ADDR_W-1:0] word_addr,
  input logic [LANE_W-1:0] lane
);
  localparam logic [LANE_W-1:0] LAST = {LANE_W{1'b1}};
  logic win_wr, win_rd, ptr_wr;
  assign win_wr = host_wr && host_sel == 2'd1;
  assign win_rd = host_rd && !host_wr && host_sel == 2'd1;
  assign ptr_wr = host_wr && (host_sel == 2'd2 || host_sel == 2'd3);

  p_single_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_rd));
  p_last_byte_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && load_en && !seq_rst && lane == LAST)
      |=> (word_addr == ADDR_W'($past(word_addr) + 1'b1)) && lane == '0);
  p_mid_byte_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && load_en && !seq_rst && lane != LAST)
      |=> $stable(word_addr) && lane == LANE_W'($past(lane) + 1'b1));
  p_ignored_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && !load_en) |=> $stable(word_addr) && $stable(lane));
  p_read_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && !seq_rst && lane == LAST)
      |=> word_addr == ADDR_W'($past(word_addr) + 1'b1));
  p_ptr_wr_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> lane == '0);
  p_seq_rst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rst |=> word_addr == '0 && lane == '0);
  p_hi_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel == 2'd3 |-> host_rdata[7:1] == 7'd0);
  p_ctrl_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel == 2'd0 |-> host_rdata == {6'd0, seq_rst, load_en});
endmodule

bind seq_pram_loader seq_pram_loader_sva #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_rd(host_rd), .host_rdata(host_rdata), .load_en(load_en),
  .seq_rst(seq_rst), .word_addr(word_addr), .lane(lane)
);

// File: tb/seq_pram_loader_test.sv
`timescale 1ns/1ps
module seq_pram_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_wdata = 8'd0;
  logic [7:0]  host_rdata;
  logic        load_en, seq_rst;
  logic [8:0]  fetch_addr = 9'd0;
  logic [31:0] fetch_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_ctrl = 0, m_addr = 0, m_lane = 0;
  logic [31:0] m_mem [int];
  logic [7:0]  m_hold [3];

  always #4 clk = ~clk;

  seq_pram_loader uut (
    .clk, .rst_n, .host_sel, .host_wr, .host_rd, .host_wdata, .host_rdata,
    .load_en, .seq_rst, .fetch_addr, .fetch_data
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step_ptr();
    if (m_lane == 3) begin m_lane = 0; m_addr = (m_addr + 1) % 512; end
    else m_lane++;
  endtask

  // One host cycle: drive, compare against the model, then advance the model.
  task automatic cyc(input logic [1:0] s, input logic w, input logic r,
                     input logic [7:0] d, input string tag);
    bit known;
    int exp_v;
    @(negedge clk);
    host_sel = s; host_wr = w; host_rd = r; host_wdata = d;
    #1;
    known = 1;
    case (s)
      2'd0: exp_v = m_ctrl;
      2'd1: if (m_mem.exists(m_addr)) exp_v = (m_mem[m_addr] >> (8*m_lane)) & 255;
            else known = 0;
      2'd2: exp_v = m_addr & 255;
      default: exp_v = m_addr >> 8;
    endcase
    if (known) check(tag, host_rdata, exp_v);
    check({tag, "/R4 ctrl pins"}, {seq_rst, load_en}, m_ctrl);
    if (m_ctrl[1]) begin
      m_addr = 0; m_lane = 0;
    end else if (w && s == 2'd2) begin
      m_addr = (m_addr & 256) | d; m_lane = 0;
    end else if (w && s == 2'd3) begin
      m_addr = (m_addr & 255) | ((d & 1) << 8); m_lane = 0;
    end else if (w && s == 2'd1 && m_ctrl[0]) begin
      if (m_lane < 3) m_hold[m_lane] = d;
      else m_mem[m_addr] = {d, m_hold[2], m_hold[1], m_hold[0]};
      step_ptr();
    end else if (r && !w && s == 2'd1) begin
      step_ptr();
    end
    if (w && s == 2'd0) m_ctrl = d & 3;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d, input string tag);
    cyc(s, 1'b1, 1'b0, d, tag);
  endtask
  task automatic rd(input logic [1:0] s, input string tag);
    cyc(s, 1'b0, 1'b1, 8'd0, tag);
  endtask
  task automatic word_wr(input logic [31:0] v, input string tag);
    for (int i = 0; i < 4; i++) wr(2'd1, v[8*i +: 8], tag);
  endtask

  task automatic fetch_chk(input logic [8:0] a, input string tag);
    @(negedge clk);
    host_wr = 0; host_rd = 0; fetch_addr = a;
    @(negedge clk); #1;
    if (m_mem.exists(int'(a))) check(tag, fetch_data, m_mem[int'(a)]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10: reset state of every register
    for (int s = 0; s < 4; s++) if (s != 1) cyc(2'(s), 0, 0, 0, "R10 reset value");
    wr(2'd0, 8'h01, "R4 set load enable");
    cyc(2'd0, 0, 0, 0, "R4 ctrl readback");
    // R1/R2: load two words
    wr(2'd2, 8'h10, "R3 addr lo");
    wr(2'd3, 8'h00, "R3 addr hi");
    wr(2'd1, 8'h11, "R1 byte0"); cyc(2'd2, 0, 0, 0, "R2 no advance lane1");
    wr(2'd1, 8'h22, "R1 byte1"); wr(2'd1, 8'h33, "R1 byte2");
    cyc(2'd2, 0, 0, 0, "R2 no advance lane3");
    wr(2'd1, 8'h44, "R1 byte3");
    cyc(2'd2, 0, 0, 0, "R2 advanced after byte3");
    word_wr(32'hCAFE_F00D, "R1 second word");
    // R6: read back
    wr(2'd2, 8'h10, "R7 re-point");
    for (int i = 0; i < 8; i++) rd(2'd1, "R6 window read");
    cyc(2'd2, 0, 0, 0, "R6 pointer after reads");
    // R7: partial word then pointer write restarts at byte 0
    wr(2'd2, 8'h20, "R3 addr lo");
    wr(2'd1, 8'hAA, "R7 partial"); wr(2'd1, 8'hBB, "R7 partial");
    wr(2'd2, 8'h20, "R7 rewrite pointer");
    word_wr(32'h0403_0201, "R7 full word after restart");
    wr(2'd2, 8'h20, "R7 re-point");
    for (int i = 0; i < 4; i++) rd(2'd1, "R7 word lanes");
    // R3/R2: high bit and wrap
    wr(2'd3, 8'hFF, "R3 hi write");
    cyc(2'd3, 0, 0, 0, "R3 hi reads bit0 only");
    wr(2'd2, 8'hFF, "R3 lo write");
    word_wr(32'h8765_4321, "R2 word at 511");
    cyc(2'd2, 0, 0, 0, "R2 wrap lo");
    cyc(2'd3, 0, 0, 0, "R2 wrap hi");
    // R5: load disabled
    wr(2'd0, 8'h00, "R4 clear load");
    wr(2'd2, 8'h10, "R5 point");
    word_wr(32'hDEAD_BEEF, "R5 ignored write");
    cyc(2'd2, 0, 0, 0, "R5 pointer unchanged");
    for (int i = 0; i < 4; i++) rd(2'd1, "R5 word unchanged");
    // R8: sequencer reset
    wr(2'd0, 8'h03, "R4 set reset");
    cyc(2'd2, 0, 0, 0, "R8 pointer cleared");
    wr(2'd2, 8'h05, "R8 ptr write blocked");
    cyc(2'd2, 0, 0, 0, "R8 pointer held");
    rd(2'd1, "R8 read while reset");
    wr(2'd0, 8'h01, "R4 release reset");
    cyc(2'd2, 0, 0, 0, "R8 pointer after release");
    // R9: fetch port
    fetch_chk(9'h010, "R9 fetch 0x10");
    fetch_chk(9'h1FF, "R9 fetch 511");
    fetch_chk(9'h020, "R9 fetch 0x20");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 9);
      if (k < 4)       wr(2'd1, 8'($urandom), "R1 random write");
      else if (k < 6)  rd(2'd1, "R6 random read");
      else if (k == 6) wr(2'd2, 8'($urandom_range(0, 7)), "R7 random lo");
      else if (k == 7) wr(2'd3, 8'($urandom), "R3 random hi");
      else if (k == 8) wr(2'd0, ($urandom_range(0, 5) == 0) ? 8'h03 : 8'h01, "R8 random ctrl");
      else             cyc(2'($urandom), 0, 0, 0, "R3 random idle");
    end
    cyc(2'd0, 0, 0, 0, "R4 final");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule